// File: doc/BRIEF.md
# Double-Buffered PWM Timebase

This block is an up-counting timebase that drives several raw pulse-width outputs from one shared period value and one duty value per channel. Each of these values is held twice: a shadow copy that software may rewrite whenever it likes, and an active copy that the counter and the comparators actually use. Shadow contents move into the active copies only on request and only at a safe point. That safe point is either the wrap of the current period or the next clock when the timebase is stopped. Because of this, a period or duty change never produces a truncated or glitched pulse.

Software starts the sequence with a clear pulse. The clear zeroes the counter so that the first period has its full length. Software then writes the shadow values, raises the load request, and sets the run level. The load request stays visible on `load_busy` until hardware performs the copy and drops it. Software polls that flag before it writes again. Each clock where the counter wraps is marked by a one-cycle pulse.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, `count` is 0, every `pwm_out` bit is 0, `period_end` is 0 and `load_busy` is 0. All shadow and active values are 0.
- R2: When `clr` is high at a rising edge, `count` becomes 0 on that edge, whatever the value of `run`. `period_end` is 0 while `clr` is high.
- R3: When `run` is 0 and `clr` is 0, `count` keeps its value. When `run` is 1 and the counter is not at the active period, `count` increases by one each clock.
- R4: When `run` is 1 and `count` equals the active period, `period_end` is 1 in that cycle and `count` returns to 0 on the next edge. One period therefore lasts period+1 clocks.
- R5: `pwm_out[i]` is 1 exactly while `count` is below channel i's active duty. A duty of 0 holds the output low, and a duty above the active period holds it high.
- R6: Shadow writes do not change `count` wrapping or `pwm_out` until a load transfers them. `per_we` writes the period shadow. `duty_we` writes the duty shadow of channel `duty_sel`, where 0 selects channel 0 and N-1 selects the last channel.
- R7: A `load_set` pulse makes `load_busy` 1 on the next edge. While `run` is 1, the copy happens on the edge that ends a period (the cycle where `period_end` is 1). `load_busy` returns to 0 on that same edge, and the new values apply from the first count of the next period.
- R8: If `load_busy` is 1 while `run` is 0, the copy and the clearing of `load_busy` happen on the next edge.
- R9: Shadow writes presented while `load_busy` is 1 are ignored. The values transferred are the ones written before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counter enable level |
| clr | input | 1 | Counter clear command |
| per_we | input | 1 | Period shadow write strobe |
| per_wdata | input | W | Period shadow write data |
| duty_we | input | 1 | Duty shadow write strobe |
| duty_sel | input | $clog2(N) | Channel whose duty shadow is written |
| duty_wdata | input | W | Duty shadow write data |
| load_set | input | 1 | Load request pulse |
| load_busy | output | 1 | Load request pending; cleared by hardware on transfer |
| count | output | W | Current counter value |
| period_end | output | 1 | High in the cycle whose edge wraps the counter |
| pwm_out | output | N | Raw compare outputs, one per channel |

## Verification
The bench targets transfers that land on the wrong edge. A design that copies the shadow values too early would shorten the running period or cut a pulse short. One that copies too late would leave `load_busy` set for a whole extra period. The bench also tests writes made while a load is pending: a block that accepts them would load the late value, not the value that was requested. The duty extremes get their own checks. A duty of 0 must stay low for the whole period, and a duty above the period must stay high, so an off-by-one comparator would let a stray one-clock pulse through. The bench also checks that a clear takes priority over run, and that a load requested while the counter is stopped completes one clock later. A design that waited for a wrap in this case would leave `load_busy` stuck high.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W  = 16,
  parameter int N  = 6,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic          per_we,
  input  logic [W-1:0]  per_wdata,
  input  logic          duty_we,
  input  logic [SW-1:0] duty_sel,
  input  logic [W-1:0]  duty_wdata,
  input  logic          load_set,
  output logic          load_busy,
  output logic [W-1:0]  count,
  output logic          period_end,
  output logic [N-1:0]  pwm_out
);

  logic [W-1:0] per_sh, per_act;
  logic [W-1:0] duty_sh  [N];
  logic [W-1:0] duty_act [N];
  logic         apply;

  assign period_end = run && !clr && (count == per_act);
  assign apply      = load_busy && (period_end || !run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (clr)        count <= '0;
    else if (period_end) count <= '0;
    else if (run)        count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        load_busy <= 1'b0;
    else if (apply)    load_busy <= 1'b0;
    else if (load_set) load_busy <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh  <= '0;
      per_act <= '0;
    end else begin
      if (per_we && !load_busy) per_sh <= per_wdata;
      if (apply)                per_act <= per_sh;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_sh[i]  <= '0;
        duty_act[i] <= '0;
      end else begin
        if (duty_we && !load_busy && int'(duty_sel) == i) duty_sh[i] <= duty_wdata;
        if (apply) duty_act[i] <= duty_sh[i];
      end
    end
    assign pwm_out[i] = count < duty_act[i];
  end

endmodule

module pwm_timebase_chk #(
  parameter int W = 16,
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         clr,
  input logic         load_set,
  input logic         load_busy,
  input logic [W-1:0] count,
  input logic         period_end,
  input logic [N-1:0] pwm_out
);

  p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

  p_clr_no_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !period_end);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(count));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !period_end) |=> count == $past(count) + 1'b1);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> count == '0);

  p_end_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> run);

  p_load_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_busy && run && !period_end) |=> load_busy);

  p_load_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_busy && load_set) |=> load_busy);

  p_load_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_busy && period_end) |=> !load_busy);

  p_idle_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_busy && !run) |=> !load_busy);

endmodule

bind pwm_timebase pwm_timebase_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .load_set(load_set),
  .load_busy(load_busy), .count(count), .period_end(period_end), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;
  localparam int W = 16;
  localparam int N = 6;
  localparam int SW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic run = 0, clr = 0, per_we = 0, duty_we = 0, load_set = 0;
  logic [W-1:0] per_wdata = '0, duty_wdata = '0;
  logic [SW-1:0] duty_sel = '0;
  logic load_busy, period_end;
  logic [W-1:0] count;
  logic [N-1:0] pwm_out;

  int checks = 0, errors = 0;
  string tag = "R1";

  logic [W-1:0] m_cnt = '0, m_psh = '0, m_pact = '0;
  logic [W-1:0] m_dsh [N];
  logic [W-1:0] m_dact [N];
  logic m_busy = 0;

  pwm_timebase #(.W(W), .N(N)) dut (.*);

  always #4 clk = ~clk;

  function automatic logic [N-1:0] exp_pwm(input logic [W-1:0] c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = c < m_dact[i];
    return r;
  endfunction

  function automatic logic exp_end();
    return run && !clr && (m_cnt == m_pact);
  endfunction

  task automatic chk(input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk({tag, " count R3"}, count, m_cnt);
    chk({tag, " pwm R5"}, W'(pwm_out), W'(exp_pwm(m_cnt)));
    chk({tag, " period_end R4"}, W'(period_end), W'(exp_end()));
    chk({tag, " load_busy R7"}, W'(load_busy), W'(m_busy));
  endtask

  task automatic step();
    logic pe, ap;
    #1 compare();
    pe = exp_end();
    ap = m_busy && (pe || !run);
    @(posedge clk);
    if (per_we && !m_busy) m_psh = per_wdata;
    if (duty_we && !m_busy) m_dsh[duty_sel] = duty_wdata;
    if (ap) begin
      m_pact = m_psh;
      for (int i = 0; i < N; i++) m_dact[i] = m_dsh[i];
      m_busy = 0;
    end else if (load_set) m_busy = 1;
    if (clr || pe) m_cnt = '0;
    else if (run) m_cnt = m_cnt + 1'b1;
    @(negedge clk);
    per_we = 0; duty_we = 0; load_set = 0; clr = 0;
  endtask

  task automatic wr_duty(input int ch, input int v);
    duty_we = 1; duty_sel = SW'(ch); duty_wdata = W'(v); step();
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin m_dsh[i] = '0; m_dact[i] = '0; end
    #20; @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1;
    step();

    tag = "R8";
    per_we = 1; per_wdata = 9; step();
    wr_duty(0, 0); wr_duty(1, 4); wr_duty(2, 20); wr_duty(3, 10); wr_duty(4, 9); wr_duty(5, 1);
    load_set = 1; step();
    step(); step();

    tag = "R5";
    clr = 1; step();
    run = 1;
    for (int k = 0; k < 25; k++) step();

    tag = "R9";
    per_we = 1; per_wdata = 5; step();
    load_set = 1; step();
    per_we = 1; per_wdata = 2; step();
    wr_duty(1, 7);
    for (int k = 0; k < 24; k++) step();

    tag = "R6";
    wr_duty(0, 3); per_we = 1; per_wdata = 12; step();
    for (int k = 0; k < 14; k++) step();
    load_set = 1; step();
    for (int k = 0; k < 20; k++) step();

    tag = "R2";
    for (int k = 0; k < 4; k++) step();
    clr = 1; step();
    step(); step();
    run = 0; clr = 1; step();
    step();

    tag = "R7";
    for (int k = 0; k < 4000; k++) begin
      run = ($urandom_range(0, 9) != 0);
      clr = ($urandom_range(0, 60) == 0);
      if ($urandom_range(0, 7) == 0) begin per_we = 1; per_wdata = W'($urandom_range(0, 20)); end
      if ($urandom_range(0, 3) == 0) begin
        duty_we = 1; duty_sel = SW'($urandom_range(0, N-1)); duty_wdata = W'($urandom_range(0, 24));
      end
      load_set = ($urandom_range(0, 15) == 0);
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule